// File: doc/BRIEF.md
# Interrupt Context Save and Restore Unit

This unit keeps the processor context that exception entry needs for a 32-bit CPU. When a software exception or a maskable interrupt is acknowledged, it captures the address of the next instruction and the program status word into an ordinary save pair. When a non-maskable interrupt is acknowledged, it captures them into a separate save pair and leaves the ordinary pair alone. Each class has one save set only, so a second event of the same class replaces the earlier values. Nesting is left to software, which can read and write all four save registers through a small register port.

On a return-from-interrupt request the unit restores the PC and PSW from one of the two pairs. A small state machine tracks whether a non-maskable handler is running. It has two states. ST_BASE is entered at reset and on a return while in ST_NMI. ST_NMI is entered on any non-maskable acknowledge. The pair that is restored is chosen by the current state. The restore values and a one-cycle load strobe appear in the cycle after the request. The PC save registers keep only bits 25:0 and the PSW save registers keep only bits 7:0. The other bits are wired to zero.

Top module: `ctx_save_unit`

## Requirements
- R1: In the cycle after `swexc_req` or `mi_ack` is sampled high with `nmi_ack` low, the exception PC register reads `next_pc & 0x03FFFFFF` and the exception PSW register reads `psw_in & 0x000000FF`.
- R2: In the cycle after `nmi_ack` is sampled high, the NMI PC and NMI PSW registers hold the masked `next_pc` and `psw_in`, and the exception pair is unchanged.
- R3: When `nmi_ack` arrives in the same cycle as `mi_ack` or `swexc_req`, only the NMI pair is written and the exception pair keeps its old contents.
- R4: Bits 31:26 of both PC save registers always read 0, and writes or saves of ones to those bits have no effect.
- R5: Bits 31:8 of both PSW save registers always read 0, and only bits 7:0 keep written or saved content.
- R6: A later event of the same class overwrites the values saved by an earlier one.
- R7: `reti_req` sampled high makes `rst_load_o` high for exactly the next cycle. In that cycle `rst_pc_o` and `rst_psw_o` carry the NMI pair if the state was ST_NMI, and the exception pair otherwise. The state moves from ST_NMI to ST_BASE on that return. `nmi_ack` moves the state to ST_NMI.
- R8: After reset all four save registers read 0, `rst_pc_o`, `rst_psw_o` and `rst_load_o` are 0, and the state is ST_BASE, so a first return restores the exception pair.
- R9: With `sw_we` high, `sw_wdata` is written to the register chosen by `sw_sel`, with the masks of R4 and R5 applied. The codes are 0 for exception PC, 1 for exception PSW, 2 for NMI PC and 3 for NMI PSW. `sw_rdata` shows the register chosen by `sw_rsel`, using the same codes, in the same cycle.
- R10: A save into a pair in the same cycle as a software write to that pair wins, and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| next_pc | input | 32 | Address of the instruction after the current one |
| psw_in | input | 32 | Current program status word |
| swexc_req | input | 1 | Software exception strobe |
| mi_ack | input | 1 | Maskable interrupt acknowledge strobe |
| nmi_ack | input | 1 | Non-maskable interrupt acknowledge strobe |
| reti_req | input | 1 | Return-from-interrupt request |
| sw_we | input | 1 | Software write enable |
| sw_sel | input | 2 | Software write register select |
| sw_wdata | input | 32 | Software write data |
| sw_rsel | input | 2 | Software read register select |
| sw_rdata | output | 32 | Software read data |
| rst_pc_o | output | 32 | Restored PC |
| rst_psw_o | output | 32 | Restored PSW |
| rst_load_o | output | 1 | One-cycle load strobe for the restore |

## Verification
A save register that holds a wrong value shows up on `sw_rdata` in the first cycle after the event that wrote it, and again on the restore outputs one cycle after the next return. A wrong state bit only shows up at a return: the unit then restores the other pair, so the bench runs returns both after an NMI and after an ordinary event. Broken priority or a broken collision rule leaves a corrupted exception pair that is visible on the read port one cycle later.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    localparam int XLEN      = 32;
    localparam int PC_KEEP   = 26;
    localparam int PSW_KEEP  = 8;
    localparam int NUM_PAIRS = 2;
    localparam int PAIR_EXC  = 0;
    localparam int PAIR_NMI  = 1;

    typedef enum logic [1:0] {
        SEL_EXC_PC  = 2'd0,
        SEL_EXC_PSW = 2'd1,
        SEL_NMI_PC  = 2'd2,
        SEL_NMI_PSW = 2'd3
    } ctx_sel_e;

    typedef enum logic {
        ST_BASE = 1'b0,
        ST_NMI  = 1'b1
    } ctx_state_e;
endpackage

// File: rtl/ctx_evt_arb.sv
module ctx_evt_arb (
    input  logic swexc_req,
    input  logic mi_ack,
    input  logic nmi_ack,
    output logic save_exc,
    output logic save_nmi
);
    // The NMI event suppresses an ordinary save in the same cycle
    always_comb begin
        save_nmi = nmi_ack;
        save_exc = (swexc_req || mi_ack) && !nmi_ack;
    end
endmodule

// File: rtl/ctx_save_pair.sv
module ctx_save_pair #(
    parameter int XLEN     = 32,
    parameter int PC_KEEP  = 26,
    parameter int PSW_KEEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_en,
    input  logic [XLEN-1:0] save_pc,
    input  logic [XLEN-1:0] save_psw,
    input  logic            wr_pc,
    input  logic            wr_psw,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] psw_q
);
    localparam int PC_ZERO  = XLEN - PC_KEEP;
    localparam int PSW_ZERO = XLEN - PSW_KEEP;

    logic [PC_KEEP-1:0]  pc_r;
    logic [PSW_KEEP-1:0] psw_r;

    // Upper bits are never stored
    logic unused_hi;
    assign unused_hi = ^{save_pc[XLEN-1:PC_KEEP], save_psw[XLEN-1:PSW_KEEP],
                         wdata[XLEN-1:PC_KEEP]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_r  <= '0;
            psw_r <= '0;
        end else if (save_en) begin
            pc_r  <= save_pc[PC_KEEP-1:0];
            psw_r <= save_psw[PSW_KEEP-1:0];
        end else begin
            if (wr_pc)  pc_r  <= wdata[PC_KEEP-1:0];
            if (wr_psw) psw_r <= wdata[PSW_KEEP-1:0];
        end
    end

    assign pc_q  = {{PC_ZERO{1'b0}}, pc_r};
    assign psw_q = {{PSW_ZERO{1'b0}}, psw_r};
endmodule

// File: rtl/ctx_save_unit.sv
module ctx_save_unit
    import ctx_pkg::*;
#(
    parameter int W       = ctx_pkg::XLEN,
    parameter int PC_BITS = ctx_pkg::PC_KEEP,
    parameter int PS_BITS = ctx_pkg::PSW_KEEP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] next_pc,
    input  logic [W-1:0] psw_in,
    input  logic         swexc_req,
    input  logic         mi_ack,
    input  logic         nmi_ack,
    input  logic         reti_req,
    input  logic         sw_we,
    input  logic [1:0]   sw_sel,
    input  logic [W-1:0] sw_wdata,
    input  logic [1:0]   sw_rsel,
    output logic [W-1:0] sw_rdata,
    output logic [W-1:0] rst_pc_o,
    output logic [W-1:0] rst_psw_o,
    output logic         rst_load_o
);
    logic             save_exc, save_nmi;
    logic             save_en [NUM_PAIRS];
    logic [W-1:0]     pair_pc [NUM_PAIRS];
    logic [W-1:0]     pair_psw[NUM_PAIRS];
    ctx_state_e       state_q, state_d;

    ctx_evt_arb u_arb (
        .swexc_req (swexc_req),
        .mi_ack    (mi_ack),
        .nmi_ack   (nmi_ack),
        .save_exc  (save_exc),
        .save_nmi  (save_nmi)
    );

    assign save_en[PAIR_EXC] = save_exc;
    assign save_en[PAIR_NMI] = save_nmi;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam logic [1:0] PC_CODE  = 2'(2 * p);
        localparam logic [1:0] PSW_CODE = 2'(2 * p + 1);
        ctx_save_pair #(.XLEN(W), .PC_KEEP(PC_BITS), .PSW_KEEP(PS_BITS)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .save_en  (save_en[p]),
            .save_pc  (next_pc),
            .save_psw (psw_in),
            .wr_pc    (sw_we && (sw_sel == PC_CODE)),
            .wr_psw   (sw_we && (sw_sel == PSW_CODE)),
            .wdata    (sw_wdata),
            .pc_q     (pair_pc[p]),
            .psw_q    (pair_psw[p])
        );
    end

    // Software read mux
    always_comb begin
        unique case (ctx_sel_e'(sw_rsel))
            SEL_EXC_PC:  sw_rdata = pair_pc[PAIR_EXC];
            SEL_EXC_PSW: sw_rdata = pair_psw[PAIR_EXC];
            SEL_NMI_PC:  sw_rdata = pair_pc[PAIR_NMI];
            SEL_NMI_PSW: sw_rdata = pair_psw[PAIR_NMI];
            default:     sw_rdata = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BASE: if (nmi_ack) state_d = ST_NMI;
            ST_NMI:  if (!nmi_ack && reti_req) state_d = ST_BASE;
            default: state_d = ST_BASE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BASE;
        else        state_q <= state_d;
    end

    // Restore outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pc_o   <= '0;
            rst_psw_o  <= '0;
            rst_load_o <= 1'b0;
        end else begin
            rst_load_o <= reti_req;
            if (reti_req) begin
                unique case (state_q)
                    ST_NMI: begin
                        rst_pc_o  <= pair_pc[PAIR_NMI];
                        rst_psw_o <= pair_psw[PAIR_NMI];
                    end
                    default: begin
                        rst_pc_o  <= pair_pc[PAIR_EXC];
                        rst_psw_o <= pair_psw[PAIR_EXC];
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ctx_save_unit_chk.sv
module ctx_save_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] next_pc,
    input logic [31:0] psw_in,
    input logic        swexc_req,
    input logic        mi_ack,
    input logic        nmi_ack,
    input logic        reti_req,
    input logic        sw_we,
    input logic [1:0]  sw_rsel,
    input logic [31:0] sw_rdata,
    input logic [31:0] rst_pc_o,
    input logic [31:0] rst_psw_o,
    input logic        rst_load_o
);
    localparam logic [31:0] PC_MASK  = (32'h1 << ctx_pkg::PC_KEEP) - 32'h1;
    localparam logic [31:0] PSW_MASK = (32'h1 << ctx_pkg::PSW_KEEP) - 32'h1;

    AST_SAVE_EXC_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (mi_ack && !nmi_ack && sw_rsel == 2'd0) |=>
        (sw_rsel != 2'd0) || (sw_rdata == ($past(next_pc) & PC_MASK))); // R1

    AST_NMI_KEEPS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ack && !sw_we && sw_rsel == 2'd0) |=>
        (sw_rsel != 2'd0) || $stable(sw_rdata)); // R2

    AST_PRIO_NMI_PSW: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ack && (mi_ack || swexc_req) && !sw_we && sw_rsel == 2'd1) |=>
        (sw_rsel != 2'd1) || $stable(sw_rdata)); // R3

    AST_PC_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rsel[0] == 1'b0) |-> (sw_rdata & ~PC_MASK) == 32'h0); // R4

    AST_PSW_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rsel[0] == 1'b1) |-> (sw_rdata & ~PSW_MASK) == 32'h0); // R5

    AST_LOAD_FOLLOWS_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        reti_req |=> rst_load_o); // R7

    AST_LOAD_ONLY_AFTER_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        !reti_req |=> !rst_load_o); // R7

    AST_RESTORE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_load_o |-> ((rst_pc_o & ~PC_MASK) == 32'h0) &&
                       ((rst_psw_o & ~PSW_MASK) == 32'h0)); // R4
endmodule

bind ctx_save_unit ctx_save_unit_chk chk_i (.*);

// File: tb/ctx_save_unit_tb_top.sv
module ctx_save_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] next_pc, psw_in, sw_wdata;
    logic        swexc_req, mi_ack, nmi_ack, reti_req, sw_we;
    logic [1:0]  sw_sel, sw_rsel;
    logic [31:0] sw_rdata, rst_pc_o, rst_psw_o;
    logic        rst_load_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ctx_save_unit dut_i (
        .clk(clk), .rst_n(rst_n), .next_pc(next_pc), .psw_in(psw_in),
        .swexc_req(swexc_req), .mi_ack(mi_ack), .nmi_ack(nmi_ack),
        .reti_req(reti_req), .sw_we(sw_we), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rsel(sw_rsel), .sw_rdata(sw_rdata),
        .rst_pc_o(rst_pc_o), .rst_psw_o(rst_psw_o), .rst_load_o(rst_load_o)
    );

    // ev = {nmi, mi, sw}
    typedef struct packed {
        logic [2:0]  ev;
        logic [31:0] pc, psw, epc, epsw, npc, npsw;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{3'b001, 32'hFFFF_FFF0, 32'h1234_56AB, 32'h03FF_FFF0, 32'h0000_00AB, 32'h0, 32'h0},
        '{3'b010, 32'h1000_0004, 32'h0000_0155, 32'h0000_0004, 32'h0000_0055, 32'h0, 32'h0},
        '{3'b100, 32'h0ABC_DEF8, 32'hFFFF_FF0F, 32'h0000_0004, 32'h0000_0055, 32'h02BC_DEF8, 32'h0000_000F},
        '{3'b110, 32'h0000_1000, 32'h0000_00C3, 32'h0000_0004, 32'h0000_0055, 32'h0000_1000, 32'h0000_00C3},
        '{3'b001, 32'h7C00_0020, 32'h0000_0022, 32'h0000_0020, 32'h0000_0022, 32'h0000_1000, 32'h0000_00C3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        sw_rsel = sel;
        #1;
        val = sw_rdata;
    endtask

    task automatic idle();
        {swexc_req, mi_ack, nmi_ack, reti_req, sw_we} = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0;
        idle();
        next_pc = '0; psw_in = '0; sw_sel = '0; sw_wdata = '0; sw_rsel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R8 reset save reg", v, 32'h0);
        end
        check("R8 reset restore pc", rst_pc_o, 32'h0);
        check("R8 reset load", {31'h0, rst_load_o}, 32'h0);

        // Vector walk: R1 R2 R3 R6 R4 R5
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            {nmi_ack, mi_ack, swexc_req} = VECS[i].ev;
            next_pc = VECS[i].pc;
            psw_in  = VECS[i].psw;
            @(negedge clk);
            idle();
            rd(2'd0, v); check("R1/R3/R6 exc pc", v, VECS[i].epc);
            rd(2'd1, v); check("R1/R5 exc psw", v, VECS[i].epsw);
            rd(2'd2, v); check("R2/R4 nmi pc", v, VECS[i].npc);
            rd(2'd3, v); check("R2/R5 nmi psw", v, VECS[i].npsw);
        end

        // R7: state is ST_NMI, return restores NMI pair
        @(negedge clk);
        reti_req = 1'b1;
        @(negedge clk);
        idle();
        check("R7 load strobe", {31'h0, rst_load_o}, 32'h1);
        check("R7 nmi restore pc", rst_pc_o, 32'h0000_1000);
        check("R7 nmi restore psw", rst_psw_o, 32'h0000_00C3);
        @(negedge clk);
        check("R7 strobe one cycle", {31'h0, rst_load_o}, 32'h0);
        // R7: back in ST_BASE, return restores exception pair
        reti_req = 1'b1;
        @(negedge clk);
        idle();
        check("R7 exc restore pc", rst_pc_o, 32'h0000_0020);
        check("R7 exc restore psw", rst_psw_o, 32'h0000_0022);

        // R9 R4 R5 software writes with masks
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            sw_we = 1'b1; sw_sel = 2'(s); sw_wdata = 32'hFFFF_FFFF;
            @(negedge clk);
            idle();
            rd(2'(s), v);
            check("R9/R4/R5 sw write masked", v, s[0] ? 32'h0000_00FF : 32'h03FF_FFFF);
        end

        // R10 save beats software write to same pair
        @(negedge clk);
        sw_we = 1'b1; sw_sel = 2'd0; sw_wdata = 32'h0000_1111;
        mi_ack = 1'b1; next_pc = 32'h0000_2222; psw_in = 32'h0000_0033;
        @(negedge clk);
        idle();
        rd(2'd0, v); check("R10 save wins pc", v, 32'h0000_2222);
        rd(2'd1, v); check("R10 save wins psw", v, 32'h0000_0033);

        done = 1'b1;
        finish_run();
    end
endmodule